// File: doc/BRIEF.md
# Block-Transfer Sequencer with Automatic Stop

This block runs the data phase of a memory-card transfer one block at a time. When the host pulses `start`, the block captures the transfer settings and holds them for the whole transfer. The settings are: single or multiple blocks, the direction, whether a block counter is used, whether a stop phase follows, and whether that stop phase waits for a completion signal instead of requesting a stop command. The block then exchanges a start/done handshake with an external data-path engine, once for each block.

In counted multi-block mode, the sequencer moves a 16-bit counter down by one for each finished block and ends on the programmed count. In uncounted multi-block mode, it keeps issuing blocks until the host raises `host_stop`. The block in progress then finishes and the transfer ends. At the end of the transfer the block pulses `xfer_done`. If the stop phase is enabled, the block then holds one of two levels until the matching acknowledge arrives:

- a request to the command path for the stop command (CMD12), or
- in completion-signal mode, an arm for completion-signal detection.

When that acknowledge arrives, the block pulses `post_done`.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy`, `blk_start`, `stop_req`, `ccs_arm`, `xfer_done` and `post_done` are all 0.
- R2: With `multi`=0 (single block), exactly one block is issued whatever `blk_count` holds, including 0. `xfer_done` then pulses once.
- R3: `blk_dir` takes the value of `dir_rd` at start (0 = write host to card, 1 = read card to host). It holds that value for the whole transfer, even if `dir_rd` changes.
- R4: With `multi`=1 and `cnt_en`=1, exactly `blk_count` blocks are issued and `host_stop` has no effect.
- R5: With `multi`=1, `cnt_en`=1 and `blk_count`=0, `xfer_done` pulses in the cycle after `start`. No block is issued and no stop phase follows.
- R6: With `multi`=1 and `cnt_en`=0, blocks are issued until `host_stop` is seen. The block in progress (also one whose `blk_done` comes in the same cycle as `host_stop`) is the last one.
- R7: With `auto_stop`=1 and `ata_mode`=0, `stop_req` rises together with the final `xfer_done` pulse and stays high until `stop_ack`. `post_done` then pulses once.
- R8: With `auto_stop`=1 and `ata_mode`=1, `ccs_arm` is used in place of `stop_req` and is released by `ccs_seen`. `stop_req` never rises and `post_done` pulses once.
- R9: With `auto_stop`=0, neither `stop_req` nor `ccs_arm` rises and `post_done` never pulses.
- R10: A `start` while `busy`=1 is ignored. It changes neither the captured settings nor the block count, and it gives no extra `xfer_done`.
- R11: `blk_start` is a one-cycle pulse. The next block is issued only after `blk_done` for the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| multi | input | 1 | 1 = multiple blocks, 0 = single block |
| dir_rd | input | 1 | 1 = read (card to host), 0 = write |
| cnt_en | input | 1 | Block counter enable (multi-block only) |
| auto_stop | input | 1 | Enable the stop phase after the last block |
| ata_mode | input | 1 | Stop phase waits for the completion signal instead of CMD12 |
| blk_count | input | CNT_W | Number of blocks for counted transfers |
| host_stop | input | 1 | Ends an uncounted transfer after the current block |
| blk_done | input | 1 | Data path finished the current block |
| stop_ack | input | 1 | Command path finished the stop command |
| ccs_seen | input | 1 | Completion signal detected |
| blk_start | output | 1 | Pulse: data path begins one block |
| blk_dir | output | 1 | Captured direction for the data path |
| busy | output | 1 | Transfer or stop phase in progress |
| stop_req | output | 1 | Request for CMD12 to the command path |
| ccs_arm | output | 1 | Completion-signal detection armed |
| xfer_done | output | 1 | Pulse when the final block completes |
| post_done | output | 1 | Pulse when the stop phase completes |

## Verification
In an uncounted transfer, the host's stop and the data path's block-done can land in the same cycle. That collision must still make the current block the last one, with no extra block issued. The bench sweeps stop positions 1 to 3. It drives `host_stop` either in the very cycle that `blk_done` is driven for the chosen block, or earlier, while that block is still being issued. In both cases the issued block count must equal the chosen position. A second collision is provoked on purpose: a fresh `start` with altered settings arrives mid-transfer. This is judged by the block count, the direction held on `blk_dir`, and a single `xfer_done`.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             multi,
  input  logic             dir_rd,
  input  logic             cnt_en,
  input  logic             auto_stop,
  input  logic             ata_mode,
  input  logic [CNT_W-1:0] blk_count,
  input  logic             host_stop,
  input  logic             blk_done,
  input  logic             stop_ack,
  input  logic             ccs_seen,
  output logic             blk_start,
  output logic             blk_dir,
  output logic             busy,
  output logic             stop_req,
  output logic             ccs_arm,
  output logic             xfer_done,
  output logic             post_done
);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_STOP, S_CCS} st_t;

  st_t              st;
  logic [CNT_W-1:0] rem;
  logic             multi_q, cnt_q, auto_q, ata_q, halt_q;

  wire counted = multi_q & cnt_q;
  wire last    = !multi_q | (cnt_q ? (rem == CNT_W'(1)) : (halt_q | host_stop));

  assign blk_start = (st == S_ISSUE);
  assign busy      = (st != S_IDLE);
  assign stop_req  = (st == S_STOP);
  assign ccs_arm   = (st == S_CCS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rem       <= '0;
      multi_q   <= 1'b0;
      cnt_q     <= 1'b0;
      auto_q    <= 1'b0;
      ata_q     <= 1'b0;
      halt_q    <= 1'b0;
      blk_dir   <= 1'b0;
      xfer_done <= 1'b0;
      post_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      post_done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          multi_q <= multi;
          cnt_q   <= cnt_en;
          auto_q  <= auto_stop;
          ata_q   <= ata_mode;
          blk_dir <= dir_rd;
          rem     <= blk_count;
          halt_q  <= 1'b0;
          if (multi && cnt_en && blk_count == '0) xfer_done <= 1'b1;
          else                                    st        <= S_ISSUE;
        end
        S_ISSUE: begin
          if (host_stop) halt_q <= 1'b1;
          st <= S_WAIT;
        end
        S_WAIT: begin
          if (host_stop) halt_q <= 1'b1;
          if (blk_done) begin
            if (last) begin
              xfer_done <= 1'b1;
              st <= auto_q ? (ata_q ? S_CCS : S_STOP) : S_IDLE;
            end else begin
              if (counted) rem <= rem - CNT_W'(1);
              st <= S_ISSUE;
            end
          end
        end
        S_STOP: if (stop_ack) begin
          post_done <= 1'b1;
          st        <= S_IDLE;
        end
        S_CCS: if (ccs_seen) begin
          post_done <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) blk_start |=> !blk_start); // R11
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n) (blk_start && counted) |-> rem != '0); // R4
  AST_STOP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(stop_req) |-> xfer_done); // R7
  AST_ARM_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ccs_arm) |-> xfer_done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |=> !xfer_done); // R2
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(blk_dir)); // R3
  AST_POST_IDLE: assert property (@(posedge clk) disable iff (!rst_n) post_done |-> !busy); // R7

endmodule

// File: tb/blk_xfer_seq_bench.sv
`timescale 1ns/1ps
module blk_xfer_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, multi = 0, dir_rd = 0, cnt_en = 0, auto_stop = 0, ata_mode = 0;
  logic [15:0] blk_count = '0;
  logic host_stop = 0, blk_done = 0, stop_ack = 0, ccs_seen = 0;
  logic blk_start, blk_dir, busy, stop_req, ccs_arm, xfer_done, post_done;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(multi), .dir_rd(dir_rd),
    .cnt_en(cnt_en), .auto_stop(auto_stop), .ata_mode(ata_mode), .blk_count(blk_count),
    .host_stop(host_stop), .blk_done(blk_done), .stop_ack(stop_ack), .ccs_seen(ccs_seen),
    .blk_start(blk_start), .blk_dir(blk_dir), .busy(busy), .stop_req(stop_req),
    .ccs_arm(ccs_arm), .xfer_done(xfer_done), .post_done(post_done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input bit m, input bit d, input bit c, input bit a, input bit t,
                     input int cnt, input int stop_at, input bit early);
    int nblk = 0, ndone = 0, npost = 0, done_cyc = -1, due = 0, ackw = 0;
    int dirbad = 0, nstop = 0, nccs = 0, dbl = 0;
    bit prev = 0, zero, exp_post;
    string tag;
    @(negedge clk);
    multi = m; dir_rd = d; cnt_en = c; auto_stop = a; ata_mode = t;
    blk_count = 16'(cnt); start = 1;
    for (int cy = 1; cy < 200; cy++) begin
      @(negedge clk);
      start = 0; blk_done = 0; host_stop = 0; stop_ack = 0; ccs_seen = 0;
      if (blk_start && prev) dbl++;
      prev = blk_start;
      if (blk_start) begin
        nblk++; due = 2;
        if (c || !m) host_stop = 1;
        if (early && m && !c && nblk == stop_at) host_stop = 1;
      end else if (due > 0) begin
        due--;
        if (due == 0) begin
          blk_done = 1;
          if (!early && m && !c && nblk == stop_at) host_stop = 1;
        end
      end
      if (xfer_done) begin ndone++; if (done_cyc < 0) done_cyc = cy; end
      if (post_done) npost++;
      if (stop_req) nstop++;
      if (ccs_arm) nccs++;
      if (stop_req || ccs_arm) begin
        ackw++;
        if (ackw == 3) begin stop_ack = stop_req; ccs_seen = ccs_arm; end
      end
      if (busy && blk_dir != d) dirbad++;
      if (cy == 4 && busy) begin
        start = 1; dir_rd = !d; blk_count = 16'(cnt + 7); multi = !m;
      end
    end
    zero = m && c && cnt == 0;
    exp_post = a && !zero;
    tag = !m ? "R2" : (c ? "R4" : "R6");
    chk(nblk == (!m ? 1 : (c ? cnt : stop_at)), tag, nblk, !m ? 1 : (c ? cnt : stop_at));
    chk(ndone == 1, "R10", ndone, 1);
    chk(dirbad == 0, "R3", dirbad, 0);
    chk(dbl == 0, "R11", dbl, 0);
    chk(npost == int'(exp_post), a ? "R7" : "R9", npost, int'(exp_post));
    chk((nstop > 0) == (exp_post && !t), "R7", nstop, int'(exp_post && !t));
    chk((nccs > 0) == (exp_post && t), "R8", nccs, int'(exp_post && t));
    if (zero) chk(done_cyc == 1 && nblk == 0, "R5", done_cyc, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({busy, blk_start, stop_req, ccs_arm, xfer_done, post_done} == 6'b0, "R1",
        int'({busy, blk_start, stop_req, ccs_arm, xfer_done, post_done}), 0);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 2; a++)
          for (int t = 0; t < 2; t++)
            for (int d = 0; d < 2; d++)
              if (m == 1 && c == 0) begin
                for (int s = 1; s <= 3; s++)
                  for (int e = 0; e < 2; e++)
                    run(1'(m), 1'(d), 1'(c), 1'(a), 1'(t), 0, s, 1'(e));
              end else begin
                for (int n = 0; n <= 4; n++)
                  run(1'(m), 1'(d), 1'(c), 1'(a), 1'(t), n, 0, 1'b0);
              end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule